// File: doc/BRIEF.md
# Add/Subtract Unit with Status Flags

This block is a 32-bit arithmetic unit for two's-complement operands. It can add, subtract, increment and decrement. Each operation gives a registered result and four status flags: negative, zero, unsigned carry and signed overflow. The caller presents two operands and a 2-bit operation code, then raises a valid strobe for one cycle. The result and the flags are captured at that clock edge, and a done pulse follows in the next cycle.

Subtraction is carried out as an addition of the bit-inverted second operand with a carry-in of one. The carry flag therefore reads 1 when the subtraction needs no borrow. Increment and decrement act on the first operand only. They update the negative, zero and overflow flags but leave the stored carry as it was. This lets a multi-word loop count with increment or decrement without disturbing a carry that an earlier add produced. The flag register keeps its value between operations.

Top module: `arith_flag_unit`

## Requirements
- R1: The negative flag equals bit 31 of the captured result.
- R2: The zero flag is 1 exactly when all 32 bits of the captured result are 0.
- R3: Add (operation code 00) gives A+B modulo 2^32, and the carry flag receives the unsigned carry out of bit 31. For example, 0xFFFFFFFF + 0x00000001 gives 0x00000000 with Z=1 and C=1.
- R4: Subtract (operation code 01) computes A + ~B + 1. The carry flag is the carry out of that sum. For example, 0 − 1 gives 0xFFFFFFFF with N=1, Z=0, C=0, V=0, and 5 − 5 gives 0 with C=1.
- R5: The overflow flag is 1 exactly when both addends of the internal sum have the same sign bit and the sign bit of the sum differs from it. For example, 0x7FFFFFFF + 1 gives 0x80000000 with V=1 and C=0.
- R6: Increment (operation code 10) and decrement (operation code 11) leave the carry flag holding its previous value.
- R7: Increment sets V only when going from 0x7FFFFFFF to 0x80000000. Decrement sets V only when going from 0x80000000 to 0x7FFFFFFF. Incrementing 0xFFFFFFFF gives 0 with V=0.
- R8: For increment and decrement, operand B has no effect on the result or on any flag.
- R9: The result and the flags are captured only at a clock edge where valid is 1, and they hold otherwise. Done is 1 for exactly the one cycle after each valid cycle.
- R10: A synchronous reset clears the result, all four flags and done to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand, ignored for increment and decrement |
| opSel | input | 2 | 00 add, 01 subtract, 10 increment A, 11 decrement A |
| valid | input | 1 | Capture strobe |
| result | output | 32 | Registered result |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |
| flagV | output | 1 | Signed overflow flag |
| done | output | 1 | One-cycle pulse after each capture |

## Verification
On every cycle, the assertions check the following:
- the zero and negative flags agree with the captured result;
- increment and decrement keep the carry;
- increment overflows only into the most negative value;
- idle cycles leave the registers unchanged;
- done follows valid by exactly one cycle.

Only the bench's scenarios can show that the arithmetic itself is right. These scenarios cover the carry and overflow values of the listed corner sums and subtractions, the fact that a garbage operand B has no effect on increment and decrement, and the carry surviving across a chain of mixed operations.

// File: rtl/aluPkg.sv
package aluPkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_INC = 2'b10,
    OP_DEC = 2'b11
  } aluOpE;

  typedef enum logic [1:0] {
    B_PASS = 2'b00,
    B_INV  = 2'b01,
    B_ZERO = 2'b10,
    B_ONES = 2'b11
  } bSelE;

  typedef struct packed {
    logic load;
    logic keepCarry;
    bSelE bSel;
    logic carryIn;
  } aluStrobeT;
endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic [1:0] opSel,
  input  logic      valid,
  output aluStrobeT strobe,
  output logic      done
);
  aluOpE opCode;
  assign opCode = aluOpE'(opSel);

  always_comb begin
    strobe.load      = valid;
    strobe.keepCarry = 1'b0;
    strobe.bSel      = B_PASS;
    strobe.carryIn   = 1'b0;
    unique case (opCode)
      OP_ADD: ;
      OP_SUB: begin
        strobe.bSel    = B_INV;
        strobe.carryIn = 1'b1;
      end
      OP_INC: begin
        strobe.bSel      = B_ZERO;
        strobe.carryIn   = 1'b1;
        strobe.keepCarry = 1'b1;
      end
      OP_DEC: begin
        strobe.bSel      = B_ONES;
        strobe.keepCarry = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= valid;
  end

  // R9: done follows each valid cycle by one cycle, and only then
  assert_done_follows_R9: assert property (@(posedge clk) disable iff (rst)
    valid |=> done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !valid |=> !done);
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobeT        strobe,
  output logic [WIDTH-1:0] result,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagC,
  output logic             flagV
);
  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] addendB;
  logic [WIDTH:0]   sumWide;
  logic [WIDTH-1:0] sum;
  logic             carryOut;
  logic             overflow;

  always_comb begin
    unique case (strobe.bSel)
      B_PASS:  addendB = opB;
      B_INV:   addendB = ~opB;
      B_ZERO:  addendB = '0;
      B_ONES:  addendB = '1;
      default: addendB = opB;
    endcase
  end

  assign sumWide  = {1'b0, opA} + {1'b0, addendB} + {{WIDTH{1'b0}}, strobe.carryIn};
  assign sum      = sumWide[WIDTH-1:0];
  assign carryOut = sumWide[WIDTH];
  assign overflow = (opA[MSB] == addendB[MSB]) && (sum[MSB] != opA[MSB]);

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      flagN  <= 1'b0;
      flagZ  <= 1'b0;
      flagC  <= 1'b0;
      flagV  <= 1'b0;
    end else if (strobe.load) begin
      result <= sum;
      flagN  <= sum[MSB];
      flagZ  <= (sum == '0);
      flagV  <= overflow;
      if (!strobe.keepCarry) flagC <= carryOut;
    end
  end

  // R1: negative flag tracks the result sign
  assert_sign_R1: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (flagN == result[MSB]));
  // R2: zero flag tracks an all-zero result
  assert_zero_R2: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (flagZ == (result == '0)));
  // R6: increment and decrement keep the stored carry
  assert_keep_carry_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.keepCarry) |=> (flagC == $past(flagC)));
  // R7: increment overflows only into the most negative value
  assert_inc_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.bSel == B_ZERO && strobe.carryIn) |=> (flagV == (result == MOST_NEG)));
  // R9: idle cycles hold result and flags
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> ($stable(result) && $stable(flagN) && $stable(flagZ)
                      && $stable(flagC) && $stable(flagV)));
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import aluPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [1:0]  opSel,
  input  logic        valid,
  output logic [31:0] result,
  output logic        flagN,
  output logic        flagZ,
  output logic        flagC,
  output logic        flagV,
  output logic        done
);
  aluStrobeT strobe;

  aluControl u_control (
    .clk    (clk),
    .rst    (rst),
    .opSel  (opSel),
    .valid  (valid),
    .strobe (strobe),
    .done   (done)
  );

  aluDatapath #(.WIDTH(32)) u_datapath (
    .clk    (clk),
    .rst    (rst),
    .opA    (opA),
    .opB    (opB),
    .strobe (strobe),
    .result (result),
    .flagN  (flagN),
    .flagZ  (flagZ),
    .flagC  (flagC),
    .flagV  (flagV)
  );
endmodule

// File: tb/arith_flag_unit_bench.sv
module arith_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] opA, opB;
  logic [1:0]  opSel;
  logic        valid;
  logic [31:0] result;
  logic        flagN, flagZ, flagC, flagV, done;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  arith_flag_unit u_arith_flag_unit (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .opSel(opSel), .valid(valid),
    .result(result), .flagN(flagN), .flagZ(flagZ), .flagC(flagC),
    .flagV(flagV), .done(done)
  );

  // {op, a, b, result, N, Z, C, V}; inc/dec carry is the previous carry
  localparam int NVEC = 14;
  localparam logic [101:0] VECS [NVEC] = '{
    {2'b00, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 4'b0110}, // R3
    {2'b10, 32'hFFFFFFFF, 32'h12345678, 32'h00000000, 4'b0110}, // R7 R6 R8
    {2'b01, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 4'b1000}, // R4
    {2'b10, 32'h7FFFFFFF, 32'hDEADBEEF, 32'h80000000, 4'b1001}, // R7
    {2'b00, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 4'b1001}, // R5
    {2'b00, 32'hFFFFFFFC, 32'h00000005, 32'h00000001, 4'b0010}, // R3
    {2'b11, 32'h80000000, 32'h00000000, 32'h7FFFFFFF, 4'b0011}, // R7 R6
    {2'b11, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'b1010}, // R6 R8
    {2'b01, 32'h00000005, 32'h00000005, 32'h00000000, 4'b0110}, // R4
    {2'b01, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 4'b0011}, // R5
    {2'b01, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 4'b1001}, // R5
    {2'b10, 32'h00000001, 32'hFFFFFFFF, 32'h00000002, 4'b0000}, // R6
    {2'b11, 32'h00000001, 32'h00000001, 32'h00000000, 4'b0100}, // R6
    {2'b00, 32'h80000000, 32'h80000000, 32'h00000000, 4'b0111}  // R3 R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    opSel = op; opA = a; opB = b; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; valid = 1'b0; opA = '0; opB = '0; opSel = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 reset state", {result, flagN, flagZ, flagC, flagV, done}, '0);

    for (int i = 0; i < NVEC; i++) begin
      runOp(VECS[i][101:100], VECS[i][99:68], VECS[i][67:36]);
      check($sformatf("R9 done vec %0d", i), {31'b0, done}, 32'd1);
      check($sformatf("R3 R4 R7 result vec %0d", i), result, VECS[i][35:4]);
      check($sformatf("R1 R2 R5 R6 flags NZCV vec %0d", i),
            {28'b0, flagN, flagZ, flagC, flagV}, {28'b0, VECS[i][3:0]});
    end

    // R9: idle inputs change, nothing captured, done stays low
    opA = 32'h11111111; opB = 32'h22222222; opSel = 2'b00;
    repeat (3) @(negedge clk);
    check("R9 hold result", result, 32'h00000000);
    check("R9 hold flags", {28'b0, flagN, flagZ, flagC, flagV}, 32'b0111);
    check("R9 done single pulse", {31'b0, done}, 32'd0);

    // R8: same inc with two different B values
    runOp(2'b10, 32'h0000FFFF, 32'h00000000);
    check("R8 inc B=0", result, 32'h00010000);
    runOp(2'b10, 32'h0000FFFF, 32'hFFFFFFFF);
    check("R8 inc B=ones", result, 32'h00010000);
    check("R8 R6 flags", {28'b0, flagN, flagZ, flagC, flagV}, 32'b0010);

    // R10: reset with flags set
    runOp(2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 reset clears", {result, flagN, flagZ, flagC, flagV, done}, '0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule